// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources into one pending vector and drives two request lines from it: a normal request and a fast request. Each request line has its own enable mask. The two masks are independent, so a source can feed either line, both lines or neither. A processor programs the masks over a word-addressed register bus. It can read the raw pending vector and the masked status of each line, and it can drive source 0 by software.

Each mask has one word that sets bits and a separate word that clears them. A write therefore changes only the bits that are one in the data and leaves the other bits alone. Pending bit 0 is the OR of hardware input 0 and a software latch. One write word sets that latch and another clears it.

The design follows FPGA practice. Reset is synchronous and active high. Both request lines and the read data are registered, so each result appears one clock edge after the cycle that produced it.

Top module: `dual_line_intc`

## Requirements
- R1: While reset is held and at the first clock after it, both masks and the software latch are zero, `irq_o` and `fiq_o` are low and `rd_data` is zero.
- R2: A read of word 1 or of word 9 returns the pending vector. Bit n of that vector is the level of `src_i[n]`, and bit 0 is also ORed with the software latch.
- R3: A write to word 2 ORs the write data into the normal-request mask. A write to word 3 clears each mask bit whose data bit is one. A read of word 2 returns the mask.
- R4: Words 10 and 11 set and clear the fast-request mask in the same way. A read of word 10 returns that mask.
- R5: A read of word 0 returns pending AND the normal mask. A read of word 8 returns pending AND the fast mask.
- R6: `irq_o` is high exactly when (pending AND normal mask) is non-zero. It is registered, so it reflects the inputs and mask present before the previous rising edge.
- R7: `fiq_o` follows (pending AND fast mask) with the same timing as `irq_o`, and independently of the normal mask.
- R8: A write of any data to word 4 sets the software latch. A write of any data to word 5 clears it. A read of word 4 returns the latch in bit 0, with all other bits zero.
- R9: Reads of the write-only words 3, 5 and 11, and of the undefined words 6, 7 and 12 to 15, return zero.
- R10: Writes to the read-only words 0, 1, 8 and 9, and to undefined words, leave both masks and the software latch unchanged.
- R11: Read data is registered. It is valid in the cycle after the one in which `rd_en` is high, and it is zero after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Level-sensitive interrupt sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Word address |
| wr_data | input | NSRC | Write data |
| rd_data | output | NSRC | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Each result has its own due cycle.

- **Read data:** a read issued on a falling edge returns its data after the next rising edge. The driver task queues the expected word when it raises `rd_en`. The monitor pops that word just after the rising edge at which `rd_en` was sampled.
- **Mask writes:** a write takes effect at the rising edge that samples it. A read issued in the following cycle therefore sees the new mask.
- **Request lines after a mask write:** the request lines respond one edge after the mask changes. The line check is taken at the falling edge that follows that second rising edge.
- **Request lines after a source change:** when only a source changes, the lines are checked one full cycle after the change. This confirms the single-register latency.

// File: rtl/dlic_pkg.sv
package dlic_pkg;
  localparam int unsigned W_IRQ_STAT  = 0;
  localparam int unsigned W_IRQ_RAW   = 1;
  localparam int unsigned W_IRQ_SET   = 2;
  localparam int unsigned W_IRQ_CLR   = 3;
  localparam int unsigned W_SW_SET    = 4;
  localparam int unsigned W_SW_CLR    = 5;
  localparam int unsigned W_FIQ_STAT  = 8;
  localparam int unsigned W_FIQ_RAW   = 9;
  localparam int unsigned W_FIQ_SET   = 10;
  localparam int unsigned W_FIQ_CLR   = 11;

  typedef struct packed {
    logic irq_set;
    logic irq_clr;
    logic fiq_set;
    logic fiq_clr;
    logic sw_set;
    logic sw_clr;
  } wr_dec_t;
endpackage

// File: rtl/dlic_mask_reg.sv
module dlic_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst)         mask <= '0;
    else if (set_we) mask <= mask | wdata;
    else if (clr_we) mask <= mask & ~wdata;
  end

  // R3 R4
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((mask & $past(wdata)) == $past(wdata)));
  // R3 R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((mask & $past(wdata)) == '0));
  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(mask));
endmodule

// File: rtl/dlic_line_out.sv
module dlic_line_out #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] mask,
  output logic [W-1:0] masked,
  output logic         line_q
);
  assign masked = pend & mask;

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b0;
    else     line_q <= |masked;
  end

  // R6 R7
  line_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask == '0) |=> !line_q);
  // R6 R7
  line_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> !line_q);
endmodule

// File: rtl/dlic_rd_mux.sv
module dlic_rd_mux
  import dlic_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  pend,
  input  logic [W-1:0]  irq_mask,
  input  logic [W-1:0]  fiq_mask,
  input  logic [W-1:0]  irq_masked,
  input  logic [W-1:0]  fiq_masked,
  input  logic          sw_latch,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == AW'(W_IRQ_STAT))      sel = irq_masked;
    else if (addr == AW'(W_IRQ_RAW))  sel = pend;
    else if (addr == AW'(W_IRQ_SET))  sel = irq_mask;
    else if (addr == AW'(W_SW_SET))   sel = {{(W-1){1'b0}}, sw_latch};
    else if (addr == AW'(W_FIQ_STAT)) sel = fiq_masked;
    else if (addr == AW'(W_FIQ_RAW))  sel = pend;
    else if (addr == AW'(W_FIQ_SET))  sel = fiq_mask;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel;
    else            rd_data <= '0;
  end

  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));
  // R9
  rd_wo_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (addr == AW'(W_IRQ_CLR) || addr == AW'(W_SW_CLR) ||
               addr == AW'(W_FIQ_CLR))) |=> (rd_data == '0));
endmodule

// File: rtl/dual_line_intc.sv
module dual_line_intc
  import dlic_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned AW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wr_data,
  output logic [NSRC-1:0] rd_data,
  output logic            irq_o,
  output logic            fiq_o
);
  wr_dec_t         dec;
  logic            sw_latch;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] irq_mask, fiq_mask;
  logic [NSRC-1:0] irq_masked, fiq_masked;

  always_comb begin
    dec         = '0;
    dec.irq_set = wr_en && (addr == AW'(W_IRQ_SET));
    dec.irq_clr = wr_en && (addr == AW'(W_IRQ_CLR));
    dec.fiq_set = wr_en && (addr == AW'(W_FIQ_SET));
    dec.fiq_clr = wr_en && (addr == AW'(W_FIQ_CLR));
    dec.sw_set  = wr_en && (addr == AW'(W_SW_SET));
    dec.sw_clr  = wr_en && (addr == AW'(W_SW_CLR));
  end

  always_ff @(posedge clk) begin
    if (rst)             sw_latch <= 1'b0;
    else if (dec.sw_set) sw_latch <= 1'b1;
    else if (dec.sw_clr) sw_latch <= 1'b0;
  end

  assign pend = src_i | {{(NSRC-1){1'b0}}, sw_latch};

  dlic_mask_reg #(.W(NSRC)) u_irq_mask (
    .clk(clk), .rst(rst), .set_we(dec.irq_set), .clr_we(dec.irq_clr),
    .wdata(wr_data), .mask(irq_mask));

  dlic_mask_reg #(.W(NSRC)) u_fiq_mask (
    .clk(clk), .rst(rst), .set_we(dec.fiq_set), .clr_we(dec.fiq_clr),
    .wdata(wr_data), .mask(fiq_mask));

  dlic_line_out #(.W(NSRC)) u_irq_line (
    .clk(clk), .rst(rst), .pend(pend), .mask(irq_mask),
    .masked(irq_masked), .line_q(irq_o));

  dlic_line_out #(.W(NSRC)) u_fiq_line (
    .clk(clk), .rst(rst), .pend(pend), .mask(fiq_mask),
    .masked(fiq_masked), .line_q(fiq_o));

  dlic_rd_mux #(.W(NSRC), .AW(AW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .pend(pend),
    .irq_mask(irq_mask), .fiq_mask(fiq_mask), .irq_masked(irq_masked),
    .fiq_masked(fiq_masked), .sw_latch(sw_latch), .rd_data(rd_data));

  // R8
  sw_set_chk: assert property (@(posedge clk) disable iff (rst)
    dec.sw_set |=> sw_latch);
  // R8
  sw_clr_chk: assert property (@(posedge clk) disable iff (rst)
    dec.sw_clr |=> !sw_latch);
  // R2
  pend_src_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend & src_i) == src_i));
endmodule

// File: tb/tb_dual_line_intc.sv
`timescale 1ns/1ps
module tb_dual_line_intc;
  localparam int NSRC = 32;
  localparam int AW   = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_i = '0;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [NSRC-1:0] wr_data = '0;
  logic [NSRC-1:0] rd_data;
  logic            irq_o, fiq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [NSRC-1:0] m_irq = '0, m_fiq = '0;
  logic            m_sw = 1'b0;

  logic [NSRC-1:0] exp_q[$];
  string           tag_q[$];

  always #2.5 clk = ~clk;

  dual_line_intc #(.NSRC(NSRC), .AW(AW)) dut (
    .clk(clk), .rst(rst), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .irq_o(irq_o), .fiq_o(fiq_o));

  function automatic logic [NSRC-1:0] m_pend();
    return src_i | {{(NSRC-1){1'b0}}, m_sw};
  endfunction

  task automatic check(input string req, input logic [NSRC-1:0] act,
                       input logic [NSRC-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: read data due just after the edge that sampled rd_en
  always @(posedge clk) begin
    if (rd_en && !rst) begin
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr(input int a, input logic [NSRC-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wr_data = d;
    case (a)
      2:  m_irq = m_irq | d;
      3:  m_irq = m_irq & ~d;
      10: m_fiq = m_fiq | d;
      11: m_fiq = m_fiq & ~d;
      4:  m_sw = 1'b1;
      5:  m_sw = 1'b0;
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [NSRC-1:0] exp, input string req);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_lines(input string req);
    @(negedge clk);
    check({req, " irq"}, {31'd0, irq_o}, {31'd0, |(m_pend() & m_irq)});
    check({req, " fiq"}, {31'd0, fiq_o}, {31'd0, |(m_pend() & m_fiq)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rst irq", {31'd0, irq_o}, 32'd0);
    check("R1 rst fiq", {31'd0, fiq_o}, 32'd0);
    check("R1 rst rd_data", rd_data, 32'd0);
    rst = 1'b0;
    rd(2, 32'd0, "R1 irq mask");
    rd(10, 32'd0, "R1 fiq mask");
    rd(4, 32'd0, "R1 sw latch");

    src_i = 32'h0000_00F0;
    rd(1, 32'h0000_00F0, "R2 raw w1");
    rd(9, 32'h0000_00F0, "R2 raw w9");
    chk_lines("R6 masks zero");

    wr(2, 32'h30); rd(2, 32'h30, "R3 set");
    wr(2, 32'h0C); rd(2, 32'h3C, "R3 or");
    wr(3, 32'h14); rd(2, 32'h28, "R3 clr");
    rd(0, 32'h20, "R5 irq status");
    chk_lines("R6 irq on");

    wr(10, 32'h80); rd(10, 32'h80, "R4 set");
    chk_lines("R7 fiq on");
    rd(8, 32'h80, "R5 fiq status");
    wr(11, 32'h80); rd(10, 32'h0, "R4 clr");
    chk_lines("R7 fiq off");

    wr(3, 32'hFFFF_FFFF);
    wr(4, 32'h0);
    rd(1, 32'h0000_00F1, "R8 raw with sw");
    rd(4, 32'h1, "R8 latch read");
    wr(2, 32'h1); chk_lines("R8 sw to irq");
    wr(5, 32'h0);
    rd(9, 32'h0000_00F0, "R8 sw cleared");
    chk_lines("R8 irq after clear");

    foreach (tag_q[i]) ;
    for (int a = 0; a < 16; a++) begin
      if (a == 3 || a == 5 || a == 11 || a == 6 || a == 7 || a >= 12)
        rd(a, 32'h0, $sformatf("R9 word %0d", a));
    end

    wr(10, 32'h0000_0100);
    foreach (src_i[i]) ;
    for (int a = 0; a < 16; a++) begin
      if (a == 0 || a == 1 || a == 8 || a == 9 || a == 6 || a == 7 || a >= 12)
        wr(a, 32'hFFFF_FFFF);
    end
    rd(2, m_irq, "R10 irq mask kept");
    rd(10, m_fiq, "R10 fiq mask kept");
    rd(4, 32'h0, "R10 sw kept");

    // one-cycle latency from a source change
    @(negedge clk); src_i = 32'h0000_0101;
    @(negedge clk);
    check("R6 latency irq", {31'd0, irq_o}, 32'd1);
    check("R7 latency fiq", {31'd0, fiq_o}, 32'd1);
    @(negedge clk); src_i = 32'h8000_0000;
    @(negedge clk);
    check("R6 drop irq", {31'd0, irq_o}, 32'd0);
    check("R7 drop fiq", {31'd0, fiq_o}, 32'd0);
    wr(10, 32'h8000_0000);
    chk_lines("R7 bit31");
    rd(8, 32'h8000_0000, "R5 bit31");

    @(negedge clk);
    check("R11 idle rd_data", rd_data, 32'd0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule